// File: doc/BRIEF.md
# Two-Wire Register Slave with Write Lock

This block is a two-wire serial slave that runs entirely on a fast system clock. It oversamples the serial clock and data lines through synchronizers. It finds start and stop conditions and bit edges, and it gives a bus master access to a bank of 16-bit registers addressed by 8-bit register numbers. The device address is set by two strap pins, so up to four identical blocks can share one bus. The data line is driven open-drain: the block only ever pulls it low, through an output-enable.

A write sends the register number and then 16-bit words, high byte first. A word is stored only when both of its bytes have arrived, and the register pointer then steps to the next register. A read sets the pointer with a short write, then uses a repeated start and the read address, and returns words high byte first with the same stepping. One reserved register number gives byte-at-a-time access. A lock register, keyed by magic values, can refuse commits either to the whole bank or only to the two image-orientation registers.

Implemented locations are 0x00 (read-only version word), 0x01 to 0x0F (general 16-bit registers) and 0xFE (lock). Every other register number reads as zero and ignores writes.

Top module: `twi_regbank`

## Requirements
- R1: The 8-bit write address is 0x90, 0x98, 0xB0 or 0xB8 for strap {1,0} values 00, 01, 10, 11; the read address is that value plus one. A transaction to any other device address is not acknowledged and changes nothing.
- R2: A write of register number N followed by bytes H then L acknowledges every byte and stores {H,L} in register N.
- R3: A write that stops after only the high byte of a word leaves the target register unchanged.
- R4: After each stored word the register pointer increments, so consecutive words in one write land in consecutive registers.
- R5: A read (pointer write, repeated start, read address) returns the pointed register high byte first; after every 16 bits the pointer increments, so a longer read returns the following registers.
- R6: A NACK from the master after a read byte ends the read; the block stops driving SDA and responds normally to the next start.
- R7: Bytewise write: a high byte written to register N (transaction then ended), followed by one byte written to register 0xF0, stores {high byte, 0xF0 byte} into N only when the 0xF0 byte completes.
- R8: Bytewise read: reading a single byte from register N returns its high byte, and a following single-byte read from register 0xF0 returns the low byte of N.
- R9: The lock register 0xFE reads 0xBEEF after reset. After 0xDEAD is written there, writes to every other register are acknowledged but not stored, while 0xFE stays writable.
- R10: After 0xDEAF is written to 0xFE, writes to 0x0D and 0x0E are not stored but other registers still are; writing 0xBEEF removes either lock.
- R11: Register 0x00 always reads the version word (default 0x1324); writes to it are acknowledged and have no effect.
- R12: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. The block drives SDA only inside a transaction addressed to it, and changes its drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| strap_sel | input | 2 | Device address select straps {1,0} |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The assertions watch every cycle that the SDA drive changes only while the synchronized clock is low. They also check that the lock register comes out of reset unlocked, that no commit ever reaches the version word, and that no commit gets past an active lock key. What only the bench scenarios can show is the protocol as a whole: address matching per strap value, refusal of half words, pointer stepping in both directions, the bytewise pairing through 0xF0, and the acknowledged-but-ignored writes. These are checked by reading the registers back over the bus against a model kept in the bench.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 16;

    localparam logic [7:0]  BYTEWISE_ADDR = 8'hF0;
    localparam logic [7:0]  LOCK_ADDR     = 8'hFE;
    localparam logic [7:0]  ORIENT_A_ADDR = 8'h0D;
    localparam logic [7:0]  ORIENT_B_ADDR = 8'h0E;

    localparam logic [15:0] KEY_OPEN   = 16'hBEEF;
    localparam logic [15:0] KEY_ALL    = 16'hDEAD;
    localparam logic [15:0] KEY_ORIENT = 16'hDEAF;

    typedef enum logic [1:0] {
        EV_START,
        EV_REGADDR,
        EV_WDATA,
        EV_RDTAKE
    } ev_kind_e;

    typedef struct packed {
        logic                valid;
        ev_kind_e            kind;
        logic [BYTE_W-1:0]   data;
    } bus_ev_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } bus_st_e;

    // 7-bit device identity selected by the straps
    function automatic logic [6:0] dev_id(input logic [1:0] strap);
        return {2'b10, strap[1], 1'b1, strap[0], 2'b00};
    endfunction

    // Whether a commit to addr is allowed under the given lock word
    function automatic logic commit_allowed(input logic [7:0] addr,
                                            input logic [15:0] lock,
                                            input int nreg);
        logic ok;
        if (addr == LOCK_ADDR) begin
            ok = 1'b1;
        end else begin
            ok = (addr != 8'h00) && (int'(addr) < nreg) && (lock != KEY_ALL)
                 && !((lock == KEY_ORIENT) &&
                      ((addr == ORIENT_A_ADDR) || (addr == ORIENT_B_ADDR)));
        end
        return ok;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain[i] <= 1'b1;
                end else if (i == 0) begin
                    chain[i] <= din;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b1;
        else     prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
    assign fall  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/twi_bus_fsm.sv
module twi_bus_fsm
    import twi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  strap_sel,
    input  logic        scl_lvl,
    input  logic        scl_rise,
    input  logic        scl_fall,
    input  logic        sda_lvl,
    input  logic        sda_rise,
    input  logic        sda_fall,
    input  logic [7:0]  rd_byte,
    output bus_ev_t     ev,
    output logic        sda_oe
);
    bus_st_e     st;
    logic [3:0]  cnt;
    logic [7:0]  sh;
    logic        is_dev;
    logic        is_read;
    logic        have_ptr;
    logic        nack;
    logic        oe_q;

    logic start_det, stop_det;
    assign start_det = scl_lvl & sda_fall;
    assign stop_det  = scl_lvl & sda_rise;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            is_dev   <= 1'b0;
            is_read  <= 1'b0;
            have_ptr <= 1'b0;
            nack     <= 1'b0;
            oe_q     <= 1'b0;
            ev       <= '0;
        end else begin
            ev.valid <= 1'b0;
            if (start_det) begin
                st      <= ST_RX;
                cnt     <= '0;
                is_dev  <= 1'b1;
                oe_q    <= 1'b0;
                ev      <= '{valid: 1'b1, kind: EV_START, data: 8'h00};
            end else if (stop_det) begin
                st   <= ST_IDLE;
                oe_q <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (scl_rise) begin
                            sh  <= {sh[6:0], sda_lvl};
                            cnt <= cnt + 4'd1;
                        end else if (scl_fall && cnt == 4'd8) begin
                            if (is_dev) begin
                                if (sh[7:1] == dev_id(strap_sel)) begin
                                    is_read  <= sh[0];
                                    have_ptr <= 1'b0;
                                    is_dev   <= 1'b0;
                                    oe_q     <= 1'b1;
                                    st       <= ST_ACK;
                                end else begin
                                    st <= ST_IDLE;
                                end
                            end else begin
                                ev       <= '{valid: 1'b1,
                                              kind: have_ptr ? EV_WDATA : EV_REGADDR,
                                              data: sh};
                                have_ptr <= 1'b1;
                                oe_q     <= 1'b1;
                                st       <= ST_ACK;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (is_read) begin
                                sh   <= rd_byte;
                                oe_q <= ~rd_byte[7];
                                st   <= ST_TX;
                                ev   <= '{valid: 1'b1, kind: EV_RDTAKE, data: 8'h00};
                            end else begin
                                oe_q <= 1'b0;
                                st   <= ST_RX;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            if (cnt == 4'd7) begin
                                oe_q <= 1'b0;
                                st   <= ST_MACK;
                            end else begin
                                sh   <= {sh[6:0], 1'b0};
                                oe_q <= ~sh[6];
                                cnt  <= cnt + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) begin
                            nack <= sda_lvl;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (nack) begin
                                st <= ST_IDLE;
                            end else begin
                                sh   <= rd_byte;
                                oe_q <= ~rd_byte[7];
                                st   <= ST_TX;
                                ev   <= '{valid: 1'b1, kind: EV_RDTAKE, data: 8'h00};
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = oe_q;
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
    import twi_pkg::*;
#(
    parameter int          NREG    = 16,
    parameter logic [15:0] VERSION = 16'h1324
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_ev_t     ev,
    output logic [7:0]  rd_byte,
    output logic [15:0] lock_word,
    output logic        commit_en,
    output logic [7:0]  commit_addr
);
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

    logic [15:0] store [NREG];
    logic [15:0] lock_q;
    logic [7:0]  ptr;
    logic        phase_lo;
    logic [7:0]  stash;
    logic [7:0]  bw_tgt;

    logic        want;
    logic [15:0] commit_data;

    // Commit request decode
    always_comb begin
        want        = 1'b0;
        commit_addr = ptr;
        commit_data = {stash, ev.data};
        if (ev.valid && ev.kind == EV_WDATA) begin
            if (ptr == BYTEWISE_ADDR) begin
                want        = 1'b1;
                commit_addr = bw_tgt;
            end else if (phase_lo) begin
                want = 1'b1;
            end
        end
    end
    assign commit_en = want && commit_allowed(commit_addr, lock_q, NREG);

    // Register storage
    generate
        for (genvar i = 0; i < NREG; i++) begin : g_reg
            if (i == 0) begin : g_ro
                assign store[i] = VERSION;
            end else begin : g_rw
                always_ff @(posedge clk) begin
                    if (rst) begin
                        store[i] <= '0;
                    end else if (commit_en && commit_addr == 8'(i)) begin
                        store[i] <= commit_data;
                    end
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= KEY_OPEN;
        end else if (commit_en && commit_addr == LOCK_ADDR) begin
            lock_q <= commit_data;
        end
    end

    // Pointer, byte phase and bytewise bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr      <= '0;
            phase_lo <= 1'b0;
            stash    <= '0;
            bw_tgt   <= '0;
        end else if (ev.valid) begin
            unique case (ev.kind)
                EV_START:   phase_lo <= 1'b0;
                EV_REGADDR: begin
                    ptr      <= ev.data;
                    phase_lo <= 1'b0;
                end
                EV_WDATA: begin
                    if (ptr != BYTEWISE_ADDR) begin
                        if (!phase_lo) begin
                            stash    <= ev.data;
                            bw_tgt   <= ptr;
                            phase_lo <= 1'b1;
                        end else begin
                            phase_lo <= 1'b0;
                            ptr      <= ptr + 8'd1;
                        end
                    end
                end
                EV_RDTAKE: begin
                    if (ptr != BYTEWISE_ADDR) begin
                        if (!phase_lo) begin
                            bw_tgt   <= ptr;
                            phase_lo <= 1'b1;
                        end else begin
                            phase_lo <= 1'b0;
                            ptr      <= ptr + 8'd1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Read data selection
    function automatic logic [15:0] word_at(input logic [7:0] a);
        logic [15:0] w;
        w = '0;
        if (a == LOCK_ADDR) begin
            w = lock_q;
        end else if (int'(a) < NREG) begin
            w = store[a[IDXW-1:0]];
        end
        return w;
    endfunction

    always_comb begin
        if (ptr == BYTEWISE_ADDR) begin
            rd_byte = word_at(bw_tgt)[7:0];
        end else if (phase_lo) begin
            rd_byte = word_at(ptr)[7:0];
        end else begin
            rd_byte = word_at(ptr)[15:8];
        end
    end

    assign lock_word = lock_q;
endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
    import twi_pkg::*;
#(
    parameter int          NREG        = 16,
    parameter logic [15:0] VERSION     = 16'h1324,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] strap_sel,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    bus_ev_t     ev;
    logic [7:0]  rd_byte;
    logic [15:0] lock_word;
    logic        commit_en;
    logic [7:0]  commit_addr;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .din(scl_i),
        .level(scl_lvl), .rise(scl_rise), .fall(scl_fall)
    );

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .din(sda_i),
        .level(sda_lvl), .rise(sda_rise), .fall(sda_fall)
    );

    twi_bus_fsm u_fsm (
        .clk(clk), .rst(rst), .strap_sel(strap_sel),
        .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_lvl(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .rd_byte(rd_byte), .ev(ev), .sda_oe(sda_oe)
    );

    twi_reg_bank #(.NREG(NREG), .VERSION(VERSION)) u_bank (
        .clk(clk), .rst(rst), .ev(ev), .rd_byte(rd_byte),
        .lock_word(lock_word), .commit_en(commit_en), .commit_addr(commit_addr)
    );
endmodule

// File: rtl/twi_regbank_chk.sv
module twi_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic        scl_lvl,
    input logic        sda_oe,
    input logic [15:0] lock_word,
    input logic        commit_en,
    input logic [7:0]  commit_addr
);
    // R12: drive changes only while the synchronized clock is low
    p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !scl_lvl);

    // R9: lock register leaves reset unlocked
    p_lock_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> (lock_word == 16'hBEEF));

    // R9: full lock lets only the lock register commit
    p_full_lock_r9: assert property (@(posedge clk) disable iff (rst)
        (commit_en && lock_word == 16'hDEAD) |-> (commit_addr == 8'hFE));

    // R10: orientation lock guards 0x0D and 0x0E
    p_orient_lock_r10: assert property (@(posedge clk) disable iff (rst)
        (commit_en && lock_word == 16'hDEAF) |->
        (commit_addr != 8'h0D && commit_addr != 8'h0E));

    // R11: the version word never receives a commit
    p_version_ro_r11: assert property (@(posedge clk) disable iff (rst)
        commit_en |-> (commit_addr != 8'h00));
endmodule

bind twi_regbank twi_regbank_chk u_chk (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
    .lock_word(lock_word), .commit_en(commit_en), .commit_addr(commit_addr)
);

// File: tb/tb_twi_regbank.sv
`timescale 1ns/100ps
module tb_twi_regbank;
    localparam int Q = 24;
    localparam logic [15:0] VER = 16'h1324;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] strap = 2'b00;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    wire  sda_line = m_sda & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic done = 1'b0;

    logic [15:0] mdl [16];
    logic [15:0] mlock;

    always #2 clk = ~clk;

    twi_regbank dut (
        .clk(clk), .rst(rst), .strap_sel(strap),
        .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_wr_addr(input logic [1:0] s);
        case (s)
            2'b00: return 8'h90;
            2'b01: return 8'h98;
            2'b10: return 8'hB0;
            default: return 8'hB8;
        endcase
    endfunction

    function automatic logic exp_writable(input logic [7:0] a);
        if (a == 8'hFE) return 1'b1;
        if (a == 8'h00 || a > 8'h0F) return 1'b0;
        if (mlock == 16'hDEAD) return 1'b0;
        if (mlock == 16'hDEAF && (a == 8'h0D || a == 8'h0E)) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic [15:0] exp_read(input logic [7:0] a);
        if (a == 8'hFE) return mlock;
        if (a == 8'h00) return VER;
        if (a <= 8'h0F) return mdl[a[3:0]];
        return 16'h0000;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [15:0] d);
        if (exp_writable(a)) begin
            if (a == 8'hFE) mlock = d;
            else mdl[a[3:0]] = d;
        end
    endtask

    // Bit-level bus tasks (entered and left with SCL low, except start from idle)
    task automatic bus_start();
        m_sda = 1'b1; #(Q); m_scl = 1'b1; #(Q); m_sda = 1'b0; #(Q); m_scl = 1'b0; #(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; #(Q); m_scl = 1'b1; #(Q); m_sda = 1'b1; #(Q);
    endtask

    task automatic bit_out(input logic b);
        m_sda = b; #(Q); m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #(Q);
    endtask

    task automatic bit_in(output logic b);
        m_sda = 1'b1; #(Q); m_scl = 1'b1; #(Q); b = sda_line; #(Q); m_scl = 1'b0; #(Q);
    endtask

    task automatic byte_out(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) bit_out(d[i]);
        bit_in(a);
        ack = ~a;
    endtask

    task automatic byte_in(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            d[i] = b;
        end
        bit_out(~give_ack);
    endtask

    task automatic wr16(input logic [7:0] a, input logic [15:0] d, output logic all_ack);
        logic k0, k1, k2, k3;
        bus_start();
        byte_out(exp_wr_addr(strap), k0);
        byte_out(a, k1);
        byte_out(d[15:8], k2);
        byte_out(d[7:0], k3);
        bus_stop();
        all_ack = k0 & k1 & k2 & k3;
        model_write(a, d);
    endtask

    task automatic set_ptr_read(input logic [7:0] a);
        logic k;
        bus_start();
        byte_out(exp_wr_addr(strap), k);
        byte_out(a, k);
        bus_start();
        byte_out(exp_wr_addr(strap) | 8'h01, k);
    endtask

    task automatic rd16(input logic [7:0] a, output logic [15:0] d);
        logic [7:0] h, l;
        set_ptr_read(a);
        byte_in(1'b1, h);
        byte_in(1'b0, l);
        bus_stop();
        d = {h, l};
    endtask

    initial begin
        #(150000 * 4);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic        ack;
        logic [15:0] w;
        logic [7:0]  b8;
        void'($urandom(32'd5150));
        for (int i = 0; i < 16; i++) mdl[i] = 16'h0000;
        mlock = 16'hBEEF;
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #3;

        // Reset state
        chk("R12 idle no drive after reset", {15'd0, sda_oe}, 16'h0000);
        rd16(8'hFE, w); chk("R9 lock reset value", w, 16'hBEEF);
        rd16(8'h00, w); chk("R11 version", w, VER);

        // R2 basic write/read
        wr16(8'h03, 16'hA55A, ack); chk("R2 all bytes acked", {15'd0, ack}, 16'h0001);
        rd16(8'h03, w); chk("R2 readback", w, 16'hA55A);

        // R1 every strap value, and foreign addresses
        for (int s = 0; s < 4; s++) begin
            strap = 2'(s);
            wr16(8'h07, 16'h1100 + 16'(s), ack);
            chk("R1 strap address acked", {15'd0, ack}, 16'h0001);
            rd16(8'h07, w); chk("R1 strap readback", w, 16'h1100 + 16'(s));
        end
        strap = 2'b01;
        bus_start();
        byte_out(8'h90, ack);
        chk("R1 foreign address not acked", {15'd0, ack}, 16'h0000);
        byte_out(8'h07, ack);
        chk("R12 no drive in foreign transaction", {15'd0, sda_oe | ack}, 16'h0000);
        byte_out(8'hFF, ack); byte_out(8'hFF, ack);
        bus_stop();
        rd16(8'h07, w); chk("R1 foreign write ignored", w, mdl[7]);

        // R3 half word then stop
        bus_start();
        byte_out(exp_wr_addr(strap), ack);
        byte_out(8'h05, ack);
        byte_out(8'hEE, ack);
        bus_stop();
        rd16(8'h05, w); chk("R3 half word not stored", w, mdl[5]);

        // R4 auto-increment write, R5 multi-word read
        bus_start();
        byte_out(exp_wr_addr(strap), ack);
        byte_out(8'h08, ack);
        for (int k = 0; k < 3; k++) begin
            byte_out(8'hC0 + 8'(k), ack);
            byte_out(8'h3C + 8'(k), ack);
            model_write(8'h08 + 8'(k), {8'hC0 + 8'(k), 8'h3C + 8'(k)});
        end
        bus_stop();
        set_ptr_read(8'h08);
        for (int k = 0; k < 3; k++) begin
            logic [7:0] hh, ll;
            byte_in(1'b1, hh);
            byte_in(k != 2, ll);
            chk("R4 R5 sequential word", {hh, ll}, {8'hC0 + 8'(k), 8'h3C + 8'(k)});
        end
        // R6 nack releases the line
        #(Q);
        chk("R6 released after nack", {15'd0, sda_oe}, 16'h0000);
        bus_stop();
        rd16(8'h09, w); chk("R6 next transaction after nack", w, 16'hC13D);

        // R7 bytewise write
        bus_start();
        byte_out(exp_wr_addr(strap), ack);
        byte_out(8'h0B, ack);
        byte_out(8'h62, ack);
        bus_stop();
        rd16(8'h0B, w); chk("R7 untouched before low byte", w, mdl[11]);
        bus_start();
        byte_out(exp_wr_addr(strap), ack);
        byte_out(8'h0B, ack);
        byte_out(8'h62, ack);
        bus_start();
        byte_out(exp_wr_addr(strap), ack);
        byte_out(8'hF0, ack);
        byte_out(8'h97, ack);
        bus_stop();
        model_write(8'h0B, 16'h6297);
        rd16(8'h0B, w); chk("R7 bytewise commit", w, 16'h6297);

        // R8 bytewise read
        wr16(8'h0C, 16'h4D2B, ack);
        set_ptr_read(8'h0C);
        byte_in(1'b0, b8);
        bus_stop();
        chk("R8 high byte", {8'h00, b8}, 16'h004D);
        set_ptr_read(8'hF0);
        byte_in(1'b0, b8);
        bus_stop();
        chk("R8 low byte via 0xF0", {8'h00, b8}, 16'h002B);

        // R11 write to version
        wr16(8'h00, 16'hFFFF, ack);
        chk("R11 write to version acked", {15'd0, ack}, 16'h0001);
        rd16(8'h00, w); chk("R11 version unchanged", w, VER);

        // R9 full lock
        wr16(8'hFE, 16'hDEAD, ack);
        wr16(8'h05, 16'h0BAD, ack);
        chk("R9 locked write acked", {15'd0, ack}, 16'h0001);
        rd16(8'h05, w); chk("R9 locked write dropped", w, mdl[5]);
        rd16(8'hFE, w); chk("R9 lock readback", w, 16'hDEAD);
        wr16(8'hFE, 16'hBEEF, ack);
        wr16(8'h05, 16'h600D, ack);
        rd16(8'h05, w); chk("R10 unlock restores writes", w, 16'h600D);

        // R10 orientation lock
        wr16(8'hFE, 16'hDEAF, ack);
        wr16(8'h0D, 16'h1234, ack);
        wr16(8'h0E, 16'h5678, ack);
        wr16(8'h06, 16'h9ABC, ack);
        rd16(8'h0D, w); chk("R10 0x0D locked", w, mdl[13]);
        rd16(8'h0E, w); chk("R10 0x0E locked", w, mdl[14]);
        rd16(8'h06, w); chk("R10 other reg writable", w, 16'h9ABC);
        wr16(8'hFE, 16'hBEEF, ack);
        wr16(8'h0D, 16'h1234, ack);
        rd16(8'h0D, w); chk("R10 0x0D after unlock", w, 16'h1234);

        // Random traffic against the model
        for (int it = 0; it < 24; it++) begin
            logic [7:0]  ra;
            logic [15:0] rd;
            ra = 8'($urandom_range(0, 16));
            if (ra == 8'd16) ra = 8'h40;
            rd = 16'($urandom);
            if ($urandom_range(0, 1) == 0) begin
                wr16(ra, rd, ack);
                chk("R2 random write acked", {15'd0, ack}, 16'h0001);
            end else begin
                rd16(ra, w);
                chk("R5 random read", w, exp_read(ra));
            end
        end
        for (int r = 0; r < 16; r++) begin
            rd16(8'(r), w);
            chk("R2 final register sweep", w, exp_read(8'(r)));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule